// File: doc/BRIEF.md
# Serial Debug Command Controller

This block sits behind a serial receiver and turns single keystrokes into adjustments of two debug controls. The first is a signed phase offset, moved by one step per key in either direction. The second is a four-bit interference-pattern selector, moved up or down by its own key pair. Each change that is accepted also produces a short ASCII report of the new value. The report goes out one byte at a time toward a serial transmitter.

Phase changes also drive a one-clock step pulse and a direction bit toward an external phase shifter. The pulse comes out in the same cycle as the register update. The bit-level serial receiver and transmitter, the phase-shift hardware and the pattern generator are separate blocks outside this one.

Top module: `dbg_cmd_ctrl`

## Requirements
- R1: After reset, `phase_offset` and `pattern_sel` are zero, `tx_valid` is low and `step_pulse` is low.
- R2: Receiving byte 0x77 ('w') while idle raises `phase_offset` by one. In the cycle the new value appears, `step_pulse` is high with `step_dir`=1. The pulse lasts exactly one clock.
- R3: Receiving byte 0x73 ('s') while idle lowers `phase_offset` by one. In the cycle the new value appears, `step_pulse` is high with `step_dir`=0. The pulse lasts exactly one clock.
- R4: The phase offset stays within -255..+255. A phase key that would move it past either limit is ignored: the register does not change, there is no step pulse and there is no report.
- R5: A phase report is the magnitude as two uppercase hex digits followed by CR (0x0D) and LF (0x0A). When the value is negative, the two digits are enclosed in '(' and ')', so -26 is sent as "(1A)" CR LF.
- R6: Byte 0x64 ('d') raises `pattern_sel` by one and byte 0x61 ('a') lowers it by one. The block then reports the new value as two uppercase hex digits followed by CR LF, for example "0F" CR LF.
- R7: A pattern key that would take `pattern_sel` below 0 or above 15 is ignored, with no report.
- R8: Any other received byte value, including the uppercase letters and bytes with bit 7 set, changes nothing and sends nothing.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold steady. Each handshake moves to the next report byte.
- R10: A byte received while a report is still being sent, up to and including the clock of its last handshake, is dropped. It causes no register change, no pulse and no extra report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received byte present this cycle |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Report byte available |
| tx_ready | input | 1 | Transmitter takes the report byte this cycle |
| tx_data | output | 8 | Report byte |
| phase_offset | output | 9 | Signed phase offset, two's complement |
| pattern_sel | output | 4 | Interference-pattern index |
| step_pulse | output | 1 | One-clock phase-step request |
| step_dir | output | 1 | Step direction, 1 = positive |

## Verification
A key that is accepted at a rising edge updates `phase_offset` or `pattern_sel` and raises `step_pulse` for the cycle that follows that edge. The first report byte is on `tx_data` in that same cycle. Each later byte appears one cycle after the handshake of the byte before it, and the pulse is gone one cycle later. The bench drives keys on falling edges and samples on the falling edge right after the accepting edge. Then, with the transmitter ready, it records one report byte per falling edge until `tx_valid` drops, so every sample lands exactly in the cycle a result is due.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

    localparam logic [7:0] KEY_PH_UP  = 8'h77;
    localparam logic [7:0] KEY_PH_DN  = 8'h73;
    localparam logic [7:0] KEY_PAT_UP = 8'h64;
    localparam logic [7:0] KEY_PAT_DN = 8'h61;

    localparam logic [7:0] CH_OPEN  = 8'h28;
    localparam logic [7:0] CH_CLOSE = 8'h29;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;

    localparam int REPORT_DIGITS = 2;
    localparam int REPORT_MAG_W  = 4 * REPORT_DIGITS;
    localparam int MSG_BYTES     = REPORT_DIGITS + 4;
    localparam int MSG_IDX_W     = $clog2(MSG_BYTES);

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_PH_UP,
        CMD_PH_DN,
        CMD_PAT_UP,
        CMD_PAT_DN
    } cmd_e;

    typedef struct packed {
        logic [MSG_BYTES-1:0][7:0] bytes;
        logic [MSG_IDX_W:0]        len;
    } msg_t;

    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        if (nib < 4'd10) hex_char = 8'h30 + {4'h0, nib};
        else             hex_char = 8'h37 + {4'h0, nib};
    endfunction

    function automatic msg_t compose(input logic neg, input logic [REPORT_MAG_W-1:0] mag);
        msg_t m;
        m = '0;
        if (neg) begin
            m.bytes[0] = CH_OPEN;
            for (int d = 0; d < REPORT_DIGITS; d++)
                m.bytes[1+d] = hex_char(mag[4*(REPORT_DIGITS-1-d) +: 4]);
            m.bytes[REPORT_DIGITS+1] = CH_CLOSE;
            m.bytes[REPORT_DIGITS+2] = CH_CR;
            m.bytes[REPORT_DIGITS+3] = CH_LF;
            m.len = (MSG_IDX_W+1)'(REPORT_DIGITS + 4);
        end else begin
            for (int d = 0; d < REPORT_DIGITS; d++)
                m.bytes[d] = hex_char(mag[4*(REPORT_DIGITS-1-d) +: 4]);
            m.bytes[REPORT_DIGITS]   = CH_CR;
            m.bytes[REPORT_DIGITS+1] = CH_LF;
            m.len = (MSG_IDX_W+1)'(REPORT_DIGITS + 2);
        end
        return m;
    endfunction

endpackage

// File: rtl/dbg_key_decode.sv
module dbg_key_decode
    import dbg_cmd_pkg::*;
(
    input  logic       valid_i,
    input  logic       enable_i,
    input  logic [7:0] data_i,
    output cmd_e       cmd_o
);

    always_comb begin
        cmd_o = CMD_NONE;
        if (valid_i && enable_i) begin
            unique case (data_i)
                KEY_PH_UP:  cmd_o = CMD_PH_UP;
                KEY_PH_DN:  cmd_o = CMD_PH_DN;
                KEY_PAT_UP: cmd_o = CMD_PAT_UP;
                KEY_PAT_DN: cmd_o = CMD_PAT_DN;
                default:    cmd_o = CMD_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dbg_phase_reg.sv
module dbg_phase_reg
    import dbg_cmd_pkg::*;
#(
    parameter int LIMIT = 255,
    parameter int W     = $clog2(LIMIT + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up_i,
    input  logic                    dn_i,
    output logic signed [W-1:0]     phase_o,
    output logic                    step_o,
    output logic                    dir_o,
    output logic                    accept_o,
    output logic                    next_neg_o,
    output logic [REPORT_MAG_W-1:0] next_mag_o
);

    localparam logic signed [W-1:0] PMAX = W'(LIMIT);
    localparam logic signed [W-1:0] PMIN = -PMAX;

    logic signed [W-1:0] phase_q;
    logic signed [W-1:0] next_val;
    logic signed [W-1:0] abs_val;
    logic                step_q;
    logic                dir_q;

    always_comb begin
        accept_o   = (up_i && (phase_q != PMAX)) || (dn_i && (phase_q != PMIN));
        next_val   = up_i ? phase_q + W'(1) : phase_q - W'(1);
        next_neg_o = next_val < 0;
        abs_val    = next_neg_o ? -next_val : next_val;
        next_mag_o = REPORT_MAG_W'(abs_val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            step_q  <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            step_q <= accept_o;
            if (accept_o) begin
                phase_q <= next_val;
                dir_q   <= up_i;
            end
        end
    end

    assign phase_o = phase_q;
    assign step_o  = step_q;
    assign dir_o   = dir_q;

    // R4
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q <= PMAX) && (phase_q >= PMIN));

    // R4
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step_q |-> $stable(phase_q));

    // R2
    phase_up_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q && dir_q) |-> (phase_q == $past(phase_q) + W'(1)));

    // R3
    phase_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (step_q && !dir_q) |-> (phase_q == $past(phase_q) - W'(1)));

endmodule

// File: rtl/dbg_pattern_reg.sv
module dbg_pattern_reg #(
    parameter int TOP = 15,
    parameter int W   = $clog2(TOP + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_i,
    input  logic         dn_i,
    output logic [W-1:0] pat_o,
    output logic         accept_o,
    output logic [W-1:0] next_o
);

    localparam logic [W-1:0] PTOP = W'(TOP);

    logic [W-1:0] pat_q;

    always_comb begin
        accept_o = (up_i && (pat_q != PTOP)) || (dn_i && (pat_q != '0));
        next_o   = up_i ? pat_q + W'(1) : pat_q - W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)           pat_q <= '0;
        else if (accept_o) pat_q <= next_o;
    end

    assign pat_o = pat_q;

    // R7
    pat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_q != $past(pat_q)) |->
            (({1'b0, pat_q} == {1'b0, $past(pat_q)} + (W+1)'(1)) ||
             ({1'b0, pat_q} + (W+1)'(1) == {1'b0, $past(pat_q)})));

endmodule

// File: rtl/dbg_report_tx.sv
module dbg_report_tx
    import dbg_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  msg_t       msg_i,
    input  logic       tx_ready,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       busy_o
);

    msg_t                 msg_q;
    logic [MSG_IDX_W-1:0] idx_q;
    logic                 busy_q;
    logic                 last_byte;

    assign last_byte = ({1'b0, idx_q} == msg_q.len - (MSG_IDX_W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_q  <= '0;
            idx_q  <= '0;
            busy_q <= 1'b0;
        end else if (load_i) begin
            msg_q  <= msg_i;
            idx_q  <= '0;
            busy_q <= 1'b1;
        end else if (busy_q && tx_ready) begin
            if (last_byte) busy_q <= 1'b0;
            else           idx_q  <= idx_q + MSG_IDX_W'(1);
        end
    end

    assign tx_valid = busy_q;
    assign tx_data  = msg_q.bytes[idx_q];
    assign busy_o   = busy_q;

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R10
    load_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load_i |-> !busy_q);

endmodule

// File: rtl/dbg_cmd_ctrl.sv
module dbg_cmd_ctrl
    import dbg_cmd_pkg::*;
#(
    parameter int PHASE_LIMIT = 255,
    parameter int PATTERN_TOP = 15,
    localparam int PHASE_W    = $clog2(PHASE_LIMIT + 1) + 1,
    localparam int PAT_W      = $clog2(PATTERN_TOP + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_data,
    output logic                      tx_valid,
    input  logic                      tx_ready,
    output logic [7:0]                tx_data,
    output logic signed [PHASE_W-1:0] phase_offset,
    output logic [PAT_W-1:0]          pattern_sel,
    output logic                      step_pulse,
    output logic                      step_dir
);

    cmd_e                    cmd;
    logic                    busy;
    logic                    ph_acc;
    logic                    ph_neg;
    logic [REPORT_MAG_W-1:0] ph_mag;
    logic                    pat_acc;
    logic [PAT_W-1:0]        pat_next;
    logic                    load;
    msg_t                    msg;

    dbg_key_decode u_decode (
        .valid_i  (rx_valid),
        .enable_i (!busy),
        .data_i   (rx_data),
        .cmd_o    (cmd)
    );

    dbg_phase_reg #(.LIMIT(PHASE_LIMIT), .W(PHASE_W)) u_phase (
        .clk        (clk),
        .rst        (rst),
        .up_i       (cmd == CMD_PH_UP),
        .dn_i       (cmd == CMD_PH_DN),
        .phase_o    (phase_offset),
        .step_o     (step_pulse),
        .dir_o      (step_dir),
        .accept_o   (ph_acc),
        .next_neg_o (ph_neg),
        .next_mag_o (ph_mag)
    );

    dbg_pattern_reg #(.TOP(PATTERN_TOP), .W(PAT_W)) u_pattern (
        .clk      (clk),
        .rst      (rst),
        .up_i     (cmd == CMD_PAT_UP),
        .dn_i     (cmd == CMD_PAT_DN),
        .pat_o    (pattern_sel),
        .accept_o (pat_acc),
        .next_o   (pat_next)
    );

    always_comb begin
        load = ph_acc || pat_acc;
        if (ph_acc) msg = compose(ph_neg, ph_mag);
        else        msg = compose(1'b0, REPORT_MAG_W'(pat_next));
    end

    dbg_report_tx u_report (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .msg_i    (msg),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .busy_o   (busy)
    );

    // R2
    step_single_chk: assert property (@(posedge clk) disable iff (rst)
        step_pulse |=> !step_pulse);

    // R10
    step_report_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(step_pulse) |-> tx_valid);

endmodule

// File: tb/dbg_cmd_ctrl_bench.sv
module dbg_cmd_ctrl_bench;

    logic              clk = 1'b0;
    logic              rst;
    logic              rx_valid;
    logic [7:0]        rx_data;
    logic              tx_valid;
    logic              tx_ready;
    logic [7:0]        tx_data;
    logic signed [8:0] phase_offset;
    logic [3:0]        pattern_sel;
    logic              step_pulse;
    logic              step_dir;

    int checks = 0;
    int errors = 0;
    int mph    = 0;
    int mpat   = 0;

    always #5 clk = ~clk;

    dbg_cmd_ctrl u_dbg_cmd_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .tx_valid     (tx_valid),
        .tx_ready     (tx_ready),
        .tx_data      (tx_data),
        .phase_offset (phase_offset),
        .pattern_sel  (pattern_sel),
        .step_pulse   (step_pulse),
        .step_dir     (step_dir)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input string act, input string exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
        end
    endtask

    function automatic string esc(input string s);
        string r = "";
        for (int i = 0; i < s.len(); i++) begin
            if (s[i] == 8'h0D)      r = {r, "<CR>"};
            else if (s[i] == 8'h0A) r = {r, "<LF>"};
            else                    r = {r, $sformatf("%c", s[i])};
        end
        return r;
    endfunction

    function automatic string hc(input int n);
        return $sformatf("%c", (n < 10) ? (8'h30 + n) : (8'h37 + n));
    endfunction

    function automatic string fmt(input int v);
        int m = (v < 0) ? -v : v;
        string d = {hc(m / 16), hc(m % 16)};
        if (v < 0) d = {"(", d, ")"};
        return {d, "\r\n"};
    endfunction

    task automatic capture(inout string got);
        for (int i = 0; i < 16; i++) begin
            if (!tx_valid) break;
            if (tx_ready) got = {got, $sformatf("%c", tx_data)};
            @(posedge clk); @(negedge clk);
        end
    endtask

    // One key, checked against the model (R2..R8)
    task automatic send_cmd(input logic [7:0] key);
        bit    ph_acc = 0;
        bit    pat_acc = 0;
        bit    up = 0;
        string expm = "";
        string got = "";
        if (key == 8'h77 && mph < 255)  begin ph_acc = 1; up = 1; mph++; end
        if (key == 8'h73 && mph > -255) begin ph_acc = 1; mph--; end
        if (key == 8'h64 && mpat < 15)  begin pat_acc = 1; mpat++; end
        if (key == 8'h61 && mpat > 0)   begin pat_acc = 1; mpat--; end
        if (ph_acc)  expm = fmt(mph);
        if (pat_acc) expm = fmt(mpat);
        @(negedge clk); rx_valid = 1'b1; rx_data = key;
        @(posedge clk); @(negedge clk); rx_valid = 1'b0;
        // R2 R3 R4: pulse and register in the same cycle
        chk(step_pulse == ph_acc, ph_acc ? (up ? "R2" : "R3") : "R4", "step_pulse",
            $sformatf("%0b", step_pulse), $sformatf("%0b", ph_acc));
        if (ph_acc)
            chk(step_dir == up, up ? "R2" : "R3", "step_dir",
                $sformatf("%0b", step_dir), $sformatf("%0b", up));
        chk(int'(phase_offset) == mph, "R4", "phase_offset",
            $sformatf("%0d", phase_offset), $sformatf("%0d", mph));
        chk(int'(pattern_sel) == mpat, "R7", "pattern_sel",
            $sformatf("%0d", pattern_sel), $sformatf("%0d", mpat));
        if (tx_valid) got = $sformatf("%c", tx_data);
        @(posedge clk); @(negedge clk);
        if (ph_acc)
            chk(step_pulse == 1'b0, "R2", "pulse width",
                $sformatf("%0b", step_pulse), "0");
        capture(got);
        chk(got == expm, ph_acc ? "R5" : (pat_acc ? "R6" : "R8"),
            $sformatf("report for key %02h", key), esc(got), esc(expm));
    endtask

    task automatic t_reset();
        // R1
        chk(phase_offset == 0, "R1", "phase reset", $sformatf("%0d", phase_offset), "0");
        chk(pattern_sel == 0, "R1", "pattern reset", $sformatf("%0d", pattern_sel), "0");
        chk(tx_valid == 0, "R1", "tx_valid reset", $sformatf("%0b", tx_valid), "0");
        chk(step_pulse == 0, "R1", "step reset", $sformatf("%0b", step_pulse), "0");
    endtask

    task automatic t_phase_up();
        // R2 R5
        send_cmd(8'h77);
        send_cmd(8'h77);
    endtask

    task automatic t_phase_down();
        // R3 R5 negative format
        for (int i = 0; i < 4; i++) send_cmd(8'h73);
    endtask

    task automatic t_other_keys();
        // R8
        send_cmd(8'h78);
        send_cmd(8'h57);
        send_cmd(8'h41);
        send_cmd(8'h00);
        send_cmd(8'hF7);
    endtask

    task automatic t_hold_ready();
        // R9
        string got = "";
        string expm;
        logic [7:0] first;
        mph++;
        expm = fmt(mph);
        @(negedge clk); tx_ready = 1'b0; rx_valid = 1'b1; rx_data = 8'h77;
        @(posedge clk); @(negedge clk); rx_valid = 1'b0;
        first = tx_data;
        chk(tx_valid == 1'b1, "R9", "valid raised", $sformatf("%0b", tx_valid), "1");
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk(tx_valid == 1'b1 && tx_data == first, "R9", "held byte",
                $sformatf("%0b/%02h", tx_valid, tx_data), $sformatf("1/%02h", first));
        end
        tx_ready = 1'b1;
        capture(got);
        chk(got == expm, "R9", "report after stall", esc(got), esc(expm));
    endtask

    task automatic t_busy_drop();
        // R10
        string got = "";
        string expm;
        mph++;
        expm = fmt(mph);
        @(negedge clk); rx_valid = 1'b1; rx_data = 8'h77;
        @(posedge clk); @(negedge clk); rx_data = 8'h73;
        if (tx_valid) got = $sformatf("%c", tx_data);
        @(posedge clk); @(negedge clk); rx_valid = 1'b0;
        capture(got);
        chk(got == expm, "R10", "single report", esc(got), esc(expm));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(tx_valid == 1'b0, "R10", "no second report", $sformatf("%0b", tx_valid), "0");
        chk(int'(phase_offset) == mph, "R10", "phase after drop",
            $sformatf("%0d", phase_offset), $sformatf("%0d", mph));
    endtask

    task automatic t_pattern();
        // R6 R7
        for (int i = 0; i < 3; i++) send_cmd(8'h64);
        for (int i = 0; i < 4; i++) send_cmd(8'h61);
        while (mpat < 15) send_cmd(8'h64);
        send_cmd(8'h64);
    endtask

    task automatic t_phase_clamp();
        // R4 R5
        while (mph < 255) send_cmd(8'h77);
        send_cmd(8'h77);
        while (mph > -255) send_cmd(8'h73);
        send_cmd(8'h73);
    endtask

    initial begin
        rst = 1'b1; rx_valid = 1'b0; rx_data = 8'h00; tx_ready = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); @(negedge clk);
        t_reset();
        t_phase_up();
        t_phase_down();
        t_other_keys();
        t_hold_ready();
        t_busy_drop();
        t_pattern();
        t_phase_clamp();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule